// File: doc/BRIEF.md
# Balanced-Ternary Word ALU

This block is a purely combinational arithmetic and logic unit for balanced-ternary words of `N_TRITS` trits (nine by default). Every trit travels as a two-bit code. The unit takes two operand words, a four-bit operation select and a carry trit held by the caller. It returns a result word and a carry-out trit.

The operations are addition, and addition that also folds in the incoming carry trit, so that words can be chained into wider arithmetic. There is negation, the tritwise operators minimum, maximum, exclusive-or, consensus and accept-anything, and an arithmetic shift. In the shift, the second operand is a signed amount, and its sign selects the direction. The unit holds no state. The caller keeps the carry trit between chained additions and feeds it back on the next carry-using addition.

Top module: `tern_alu`

## Requirements
- R1: Trit codes are 2'b10 = -1, 2'b00 = 0 and 2'b01 = +1. An input trit (operand or carry) coded 2'b11 behaves exactly as 0. No result or carry trit is ever driven as 2'b11.
- R2: Op 4'd0 adds. The result value plus carry-out times 3^N_TRITS equals x + y. The incoming carry trit has no effect.
- R3: Op 4'd1 adds with carry. The result value plus carry-out times 3^N_TRITS equals x + y + carry_i.
- R4: Op 4'd2 returns the arithmetic negation of y, which is y with every trit inverted.
- R5: Op 4'd3 returns the tritwise minimum of x and y. Op 4'd4 returns the tritwise maximum.
- R6: Op 4'd5 returns the tritwise exclusive-or, where each result trit is the negated product of the two operand trits.
- R7: Op 4'd6 (consensus) gives the common trit where the two trits agree, and 0 elsewhere. Op 4'd7 (accept-anything) gives the common trit where the trits agree, gives the nonzero trit where the other trit is 0, and gives 0 where the trits are opposite.
- R8: Op 4'd8 shifts. With amount k = value of y and 0 < |k| < N_TRITS, result trit i equals x trit i+k. Positive k moves trits toward lower positions and negative k moves them toward higher positions. Vacated positions become 0. When k = 0 the result is x.
- R9: For op 4'd8 with |k| >= N_TRITS, the result is all zeros.
- R10: Every operation other than 4'd0 and 4'd1 returns carry-out 0. Op codes 4'd9 to 4'd15 return result 0 and carry-out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation select |
| x_i | input | 2*N_TRITS | First operand word |
| y_i | input | 2*N_TRITS | Second operand word, or the signed shift amount |
| carry_i | input | 2 | Carry trit kept by the caller, used only by add-with-carry |
| result_o | output | 2*N_TRITS | Result word |
| carry_o | output | 2 | Carry-out trit of the addition operations |

## Verification
The bench builds two copies of the unit. The first uses N_TRITS = 3, which makes it practical to sweep every operation code, every pair of operand values and every carry trit. That sweep reaches every shift amount, including those at or beyond the word width, and every wrap of the adder in both directions. The second copy uses the default N_TRITS = 9. There the ±9841 extremes, operand pairs near the carry boundary, a full sweep of shift amounts from -12 to +12, pseudo-random operands and the invalid 2'b11 code on operands and carry are compared against values worked out arithmetically in the bench.

// File: rtl/tern_alu_pkg.sv
`timescale 1ns/1ps
// Shared trit type, trit codes, operation codes and conversion helpers for
// the balanced-ternary ALU. Assumes trits are two-bit codes in which 2'b11
// carries no meaning and is read as zero.
package tern_alu_pkg;

    typedef logic [1:0] trit_t;

    localparam trit_t TRIT_NEG  = 2'b10;
    localparam trit_t TRIT_ZERO = 2'b00;
    localparam trit_t TRIT_POS  = 2'b01;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 4'd0,
        OP_ADC   = 4'd1,
        OP_NEG   = 4'd2,
        OP_MIN   = 4'd3,
        OP_MAX   = 4'd4,
        OP_XOR   = 4'd5,
        OP_CON   = 4'd6,
        OP_ANY   = 4'd7,
        OP_SHIFT = 4'd8
    } alu_op_e;

    // Map a trit code to -1, 0 or +1; the invalid code reads as 0.
    function automatic int trit_to_int(trit_t t);
        case (t)
            TRIT_POS: return 1;
            TRIT_NEG: return -1;
            default:  return 0;
        endcase
    endfunction

    // Map the sign of an integer to a trit code.
    function automatic trit_t int_to_trit(int v);
        if (v > 0)
            return TRIT_POS;
        else if (v < 0)
            return TRIT_NEG;
        else
            return TRIT_ZERO;
    endfunction

    // Replace the invalid code by zero and pass valid codes unchanged.
    function automatic trit_t trit_clean(trit_t t);
        return (t == 2'b11) ? TRIT_ZERO : t;
    endfunction

endpackage

// File: rtl/tern_fa.sv
`timescale 1ns/1ps
// Balanced-ternary full adder: adds three trits and gives a sum trit and a
// carry trit, both in {-1, 0, +1}. Assumes the codes at its inputs are valid.
module tern_fa
    import tern_alu_pkg::*;
(
    input  trit_t a_i,
    input  trit_t b_i,
    input  trit_t c_i,
    output trit_t s_o,
    output trit_t c_o
);

    // Fold the column total (-3..+3) into one sum trit and one carry trit.
    always_comb begin
        int total;
        total = trit_to_int(a_i) + trit_to_int(b_i) + trit_to_int(c_i);
        if (total >= 2) begin
            s_o = int_to_trit(total - 3);
            c_o = TRIT_POS;
        end else if (total <= -2) begin
            s_o = int_to_trit(total + 3);
            c_o = TRIT_NEG;
        end else begin
            s_o = int_to_trit(total);
            c_o = TRIT_ZERO;
        end
    end

    // Check that the column value is preserved by sum plus three times carry.
    always_comb begin
        if (!$isunknown({a_i, b_i, c_i, s_o, c_o})) begin
            // R2
            fa_value_chk: assert (trit_to_int(s_o) + 3 * trit_to_int(c_o) ==
                                  trit_to_int(a_i) + trit_to_int(b_i) + trit_to_int(c_i))
                else $error("full adder lost value");
        end
    end

endmodule

// File: rtl/tern_adder.sv
`timescale 1ns/1ps
// Ripple adder of N_TRITS balanced-ternary full adders. The incoming carry
// enters at trit 0 and the carry out of the top trit is exported. Assumes
// cleaned trit codes at its inputs.
module tern_adder
    import tern_alu_pkg::*;
#(
    parameter int N_TRITS = 9
) (
    input  logic [2*N_TRITS-1:0] a_i,
    input  logic [2*N_TRITS-1:0] b_i,
    input  trit_t                c_i,
    output logic [2*N_TRITS-1:0] sum_o,
    output trit_t                c_o
);

    trit_t chain [0:N_TRITS];

    assign chain[0] = c_i;
    assign c_o      = chain[N_TRITS];

    // One full adder per trit position, linked by the carry chain.
    for (genvar g = 0; g < N_TRITS; g++) begin : g_col
        tern_fa u_fa (
            .a_i (a_i[2*g +: 2]),
            .b_i (b_i[2*g +: 2]),
            .c_i (chain[g]),
            .s_o (sum_o[2*g +: 2]),
            .c_o (chain[g+1])
        );
    end

endmodule

// File: rtl/tern_logic.sv
`timescale 1ns/1ps
// Tritwise operators: negation of b, minimum, maximum, exclusive-or
// (negated product), consensus and accept-anything. Each trit position is
// independent. Opcodes that are not tritwise produce zero.
module tern_logic
    import tern_alu_pkg::*;
#(
    parameter int N_TRITS = 9
) (
    input  logic [OP_W-1:0]      op_i,
    input  logic [2*N_TRITS-1:0] a_i,
    input  logic [2*N_TRITS-1:0] b_i,
    output logic [2*N_TRITS-1:0] res_o
);

    for (genvar g = 0; g < N_TRITS; g++) begin : g_trit
        // Evaluate the selected operator on one trit pair.
        always_comb begin
            int a;
            int b;
            int r;
            a = trit_to_int(a_i[2*g +: 2]);
            b = trit_to_int(b_i[2*g +: 2]);
            case (op_i)
                OP_NEG: r = -b;
                OP_MIN: r = (a < b) ? a : b;
                OP_MAX: r = (a > b) ? a : b;
                OP_XOR: r = -(a * b);
                OP_CON: r = (a == b) ? a : 0;
                OP_ANY: begin
                    if (a == b)
                        r = a;
                    else if (a == 0)
                        r = b;
                    else if (b == 0)
                        r = a;
                    else
                        r = 0;
                end
                default: r = 0;
            endcase
            res_o[2*g +: 2] = int_to_trit(r);
        end

        // Check the exclusive-or trit against the product rule.
        always_comb begin
            if (!$isunknown({op_i, a_i[2*g +: 2], b_i[2*g +: 2], res_o[2*g +: 2]})) begin
                if (op_i == OP_XOR) begin
                    // R6
                    xor_product_chk: assert (trit_to_int(res_o[2*g +: 2]) ==
                        -(trit_to_int(a_i[2*g +: 2]) * trit_to_int(b_i[2*g +: 2])))
                        else $error("xor trit wrong");
                end
            end
        end
    end

endmodule

// File: rtl/tern_shifter.sv
`timescale 1ns/1ps
// Arithmetic trit shifter. The amount word is read as a signed balanced-
// ternary value k. Positive k moves trits toward position 0, negative k
// toward the top, and vacated positions take zero. When |k| >= N_TRITS the
// result is zero. Assumes cleaned trit codes at its inputs.
module tern_shifter
    import tern_alu_pkg::*;
#(
    parameter int N_TRITS = 9
) (
    input  logic [2*N_TRITS-1:0] a_i,
    input  logic [2*N_TRITS-1:0] amt_i,
    output logic [2*N_TRITS-1:0] res_o
);

    int amount;

    // Evaluate the signed shift amount, most significant trit first.
    always_comb begin
        amount = 0;
        for (int i = N_TRITS - 1; i >= 0; i--)
            amount = amount * 3 + trit_to_int(amt_i[2*i +: 2]);
    end

    // Select the source trit for every destination position.
    always_comb begin
        res_o = '0;
        if (amount < N_TRITS && amount > -N_TRITS) begin
            for (int i = 0; i < N_TRITS; i++) begin
                if (i + amount >= 0 && i + amount < N_TRITS)
                    res_o[2*i +: 2] = a_i[2*(i + amount) +: 2];
            end
        end
    end

    // Check zero fill at the vacated end and the out-of-range case.
    always_comb begin
        if (!$isunknown({a_i, amt_i, res_o})) begin
            if (amount > 0 && amount < N_TRITS) begin
                // R8
                shift_fill_hi_chk: assert (res_o[2*N_TRITS-1 -: 2] == TRIT_ZERO)
                    else $error("top trit not vacated");
            end
            if (amount < 0 && amount > -N_TRITS) begin
                // R8
                shift_fill_lo_chk: assert (res_o[1:0] == TRIT_ZERO)
                    else $error("bottom trit not vacated");
            end
            if (amount >= N_TRITS || amount <= -N_TRITS) begin
                // R9
                shift_range_chk: assert (res_o == '0)
                    else $error("oversized shift not zero");
            end
        end
    end

endmodule

// File: rtl/tern_alu.sv
`timescale 1ns/1ps
// Balanced-ternary ALU top. It cleans invalid trit codes, then selects among
// the ripple adder, the tritwise unit and the shifter. It holds no state: the
// caller keeps the carry trit between chained add-with-carry operations.
module tern_alu
    import tern_alu_pkg::*;
#(
    parameter int N_TRITS = 9
) (
    input  logic [3:0]           op_i,
    input  logic [2*N_TRITS-1:0] x_i,
    input  logic [2*N_TRITS-1:0] y_i,
    input  logic [1:0]           carry_i,
    output logic [2*N_TRITS-1:0] result_o,
    output logic [1:0]           carry_o
);

    localparam int W = 2 * N_TRITS;

    logic [W-1:0] x_cl;
    logic [W-1:0] y_cl;
    trit_t        cin_sel;
    logic [W-1:0] sum_w;
    trit_t        cout_w;
    logic [W-1:0] logic_w;
    logic [W-1:0] shift_w;

    // Replace invalid codes on both operands trit by trit.
    for (genvar g = 0; g < N_TRITS; g++) begin : g_clean
        assign x_cl[2*g +: 2] = trit_clean(x_i[2*g +: 2]);
        assign y_cl[2*g +: 2] = trit_clean(y_i[2*g +: 2]);
    end

    // Feed the stored carry only for add-with-carry.
    assign cin_sel = (op_i == OP_ADC) ? trit_clean(carry_i) : TRIT_ZERO;

    tern_adder #(.N_TRITS(N_TRITS)) u_adder (
        .a_i   (x_cl),
        .b_i   (y_cl),
        .c_i   (cin_sel),
        .sum_o (sum_w),
        .c_o   (cout_w)
    );

    tern_logic #(.N_TRITS(N_TRITS)) u_logic (
        .op_i  (op_i),
        .a_i   (x_cl),
        .b_i   (y_cl),
        .res_o (logic_w)
    );

    tern_shifter #(.N_TRITS(N_TRITS)) u_shift (
        .a_i   (x_cl),
        .amt_i (y_cl),
        .res_o (shift_w)
    );

    // Pick the result and carry of the selected unit.
    always_comb begin
        result_o = '0;
        carry_o  = TRIT_ZERO;
        case (op_i)
            OP_ADD, OP_ADC: begin
                result_o = sum_w;
                carry_o  = cout_w;
            end
            OP_NEG, OP_MIN, OP_MAX, OP_XOR, OP_CON, OP_ANY: result_o = logic_w;
            OP_SHIFT: result_o = shift_w;
            default: ;
        endcase
    end

    // Check output code validity, idle carry and negation at the ports.
    always_comb begin
        if (!$isunknown({op_i, x_i, y_i, carry_i, result_o, carry_o})) begin
            // R1
            code_valid_chk: assert (carry_o != 2'b11)
                else $error("invalid carry code");
            for (int i = 0; i < N_TRITS; i++) begin
                // R1
                trit_valid_chk: assert (result_o[2*i +: 2] != 2'b11)
                    else $error("invalid result code");
            end
            if (op_i != OP_ADD && op_i != OP_ADC) begin
                // R10
                carry_idle_chk: assert (carry_o == TRIT_ZERO)
                    else $error("carry set by non-add op");
            end
            if (op_i == OP_NEG) begin
                for (int i = 0; i < N_TRITS; i++) begin
                    // R4
                    neg_inverse_chk: assert (trit_to_int(result_o[2*i +: 2]) +
                                             trit_to_int(y_i[2*i +: 2]) == 0)
                        else $error("negation trit wrong");
                end
            end
        end
    end

endmodule

// File: tb/tern_alu_bench.sv
`timescale 1ns/1ps
// Bench for tern_alu: an exhaustive sweep of a 3-trit copy plus boundary,
// shift and random sweeps of the default 9-trit copy, all compared with
// values computed arithmetically here.
module tern_alu_bench;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    logic [3:0]  op9 = '0;
    logic [17:0] x9  = '0;
    logic [17:0] y9  = '0;
    logic [1:0]  c9  = '0;
    logic [17:0] r9;
    logic [1:0]  co9;

    logic [3:0]  op3 = '0;
    logic [5:0]  x3  = '0;
    logic [5:0]  y3  = '0;
    logic [1:0]  c3  = '0;
    logic [5:0]  r3;
    logic [1:0]  co3;

    tern_alu #(.N_TRITS(9)) u_tern_alu (
        .op_i(op9), .x_i(x9), .y_i(y9), .carry_i(c9), .result_o(r9), .carry_o(co9)
    );

    tern_alu #(.N_TRITS(3)) u_tern_alu_n3 (
        .op_i(op3), .x_i(x3), .y_i(y3), .carry_i(c3), .result_o(r3), .carry_o(co3)
    );

    function automatic int pw3(int n);
        int p = 1;
        for (int i = 0; i < n; i++) p = p * 3;
        return p;
    endfunction

    // Balanced trit i of an integer.
    function automatic int tv(int v, int i);
        int r = 0;
        for (int k = 0; k <= i; k++) begin
            r = ((v % 3) + 3) % 3;
            if (r == 2) r = -1;
            v = (v - r) / 3;
        end
        return r;
    endfunction

    function automatic logic [17:0] enc(int v, int n);
        logic [17:0] w = '0;
        for (int i = 0; i < n; i++) begin
            int t = tv(v, i);
            w[2*i +: 2] = (t > 0) ? 2'b01 : (t < 0) ? 2'b10 : 2'b00;
        end
        return w;
    endfunction

    function automatic int dec(logic [17:0] w, int n);
        int v = 0;
        for (int i = 0; i < n; i++) begin
            if (w[2*i +: 2] == 2'b01) v += pw3(i);
            if (w[2*i +: 2] == 2'b10) v -= pw3(i);
        end
        return v;
    endfunction

    function automatic bit has_bad(logic [17:0] w, int n);
        bit b = 1'b0;
        for (int i = 0; i < n; i++) if (w[2*i +: 2] == 2'b11) b = 1'b1;
        return b;
    endfunction

    // Expected result and carry for one operation.
    function automatic void ref_op(input int n, input int op, input int x, input int y,
                                   input int c, output int r, output int co);
        int half = (pw3(n) - 1) / 2;
        int s;
        r = 0;
        co = 0;
        case (op)
            0, 1: begin
                s = x + y + ((op == 1) ? c : 0);
                if (s > half) begin co = 1; s -= pw3(n); end
                else if (s < -half) begin co = -1; s += pw3(n); end
                r = s;
            end
            2: r = -y;
            3, 4, 5, 6, 7: begin
                for (int i = 0; i < n; i++) begin
                    int a = tv(x, i);
                    int b = tv(y, i);
                    int t = 0;
                    case (op)
                        3: t = (a < b) ? a : b;
                        4: t = (a > b) ? a : b;
                        5: t = -(a * b);
                        6: t = (a == b) ? a : 0;
                        default: t = (a == b) ? a : (a == 0) ? b : (b == 0) ? a : 0;
                    endcase
                    r += t * pw3(i);
                end
            end
            8: begin
                if (y < n && y > -n)
                    for (int i = 0; i < n; i++)
                        if (i + y >= 0 && i + y < n) r += tv(x, i + y) * pw3(i);
            end
            default: r = 0;
        endcase
    endfunction

    function automatic string tag_of(int op, int y, int n);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3, 4: return "R5";
            5: return "R6";
            6, 7: return "R7";
            8: return (y >= n || y <= -n) ? "R9" : "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic compare(string tag, logic [17:0] rw, logic [1:0] cw, int n,
                           int exp_r, int exp_c);
        int got_r = dec(rw, n);
        int got_c = dec({16'b0, cw}, 1);
        n_checks++;
        if (has_bad(rw, n) || got_r != exp_r) begin
            n_errors++;
            $display("FAIL %s n=%0d result got %0d (raw %h) expected %0d", tag, n, got_r, rw, exp_r);
        end
        n_checks++;
        if (cw == 2'b11 || got_c != exp_c) begin
            n_errors++;
            $display("FAIL %s n=%0d carry got %0d (raw %b) expected %0d", tag, n, got_c, cw, exp_c);
        end
    endtask

    task automatic drive9(logic [3:0] op, logic [17:0] xw, logic [17:0] yw, logic [1:0] cw,
                          int exp_r, int exp_c, string tag);
        @(negedge clk);
        op9 = op; x9 = xw; y9 = yw; c9 = cw;
        #5;
        compare(tag, r9, co9, 9, exp_r, exp_c);
    endtask

    task automatic run9(int op, int x, int y, int c);
        int r;
        int co;
        logic [17:0] cw = enc(c, 1);
        ref_op(9, op, x, y, c, r, co);
        drive9(op[3:0], enc(x, 9), enc(y, 9), cw[1:0], r, co, tag_of(op, y, 9));
    endtask

    task automatic run3(int op, int x, int y, int c);
        int r;
        int co;
        logic [17:0] xw = enc(x, 3);
        logic [17:0] yw = enc(y, 3);
        logic [17:0] cw = enc(c, 1);
        ref_op(3, op, x, y, c, r, co);
        @(negedge clk);
        op3 = op[3:0]; x3 = xw[5:0]; y3 = yw[5:0]; c3 = cw[1:0];
        #5;
        compare(tag_of(op, y, 3), {12'b0, r3}, co3, 3, r, co);
    endtask

    int edge_vals [10] = '{0, 1, -1, 9841, -9841, 4920, -4921, 3280, 13, -13};

    initial begin
        int unsigned seed = 32'd12345;
        logic [17:0] xw;
        logic [17:0] yw;
        int r;
        int co;

        // Idle state: all-zero inputs give zero result and carry (R2, R10).
        drive9(4'd0, '0, '0, 2'b00, 0, 0, "R2 idle");
        drive9(4'd9, '0, '0, 2'b00, 0, 0, "R10 idle");

        // 9-trit boundary values across all used ops and two unused ones.
        for (int op = 0; op <= 10; op++)
            for (int a = 0; a < 10; a++)
                for (int b = 0; b < 10; b++)
                    for (int c = -1; c <= 1; c++)
                        run9((op == 10) ? 15 : op, edge_vals[a], edge_vals[b], c);

        // Shift amounts across and beyond the word width (R8, R9).
        for (int k = -12; k <= 12; k++) begin
            run9(8, 7654, k, 0);
            run9(8, -9841, k, 1);
        end

        // Pseudo-random operands.
        for (int i = 0; i < 2000; i++) begin
            int x;
            int y;
            int c;
            seed = seed * 32'd1103515245 + 32'd12345;
            x = int'((seed >> 8) % 32'd19683) - 9841;
            seed = seed * 32'd1103515245 + 32'd12345;
            y = int'((seed >> 8) % 32'd19683) - 9841;
            seed = seed * 32'd1103515245 + 32'd12345;
            c = int'((seed >> 8) % 32'd3) - 1;
            run9(i % 9, x, y, c);
        end

        // R1: invalid code 2'b11 on an operand trit reads as 0.
        xw = enc(1, 9); xw[7:6] = 2'b11;
        ref_op(9, 0, 1, 5, 0, r, co);
        drive9(4'd0, xw, enc(5, 9), 2'b00, r, co, "R1 add x-code");
        ref_op(9, 7, 1, -4, 0, r, co);
        drive9(4'd7, xw, enc(-4, 9), 2'b00, r, co, "R1 any x-code");
        yw = enc(-2, 9); yw[17:16] = 2'b11;
        ref_op(9, 2, 0, -2, 0, r, co);
        drive9(4'd2, enc(100, 9), yw, 2'b00, r, co, "R1 neg y-code");
        // R1 and R3: carry coded 2'b11 reads as 0.
        ref_op(9, 1, 9841, 0, 0, r, co);
        drive9(4'd1, enc(9841, 9), enc(0, 9), 2'b11, r, co, "R1 adc carry-code");
        ref_op(9, 1, 9841, 0, 1, r, co);
        drive9(4'd1, enc(9841, 9), enc(0, 9), 2'b01, r, co, "R3 adc wrap");

        // Exhaustive 3-trit sweep of every op, operand pair and carry trit.
        for (int op = 0; op < 16; op++)
            for (int x = -13; x <= 13; x++)
                for (int y = -13; y <= 13; y++)
                    for (int c = -1; c <= 1; c++)
                        run3(op, x, y, c);

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #4000000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule